// File: doc/BRIEF.md
# Serial Receiver with Line Status

This block takes an asynchronous serial line and turns each received character into a receive-buffer byte plus a status byte with the usual line-status flags. The line first passes through a synchroniser. A programmable prescaler then produces an oversampling tick, sixteen ticks per bit by default. A frame engine finds the start bit and confirms it, then samples the data bits, the optional parity bit and the stop bit, each in the middle of its bit.

The frame settings use the same field encoding that a matching transmitter uses: word length, parity enable, even parity and stick parity. The receive buffer holds one character. Data-ready, overrun, parity, framing and break flags are kept in a status byte. The error flags stay set until software reads the status byte. Reading the buffer clears data-ready. Two transmitter conditions come in from outside and are folded into the status byte, so the byte can be read as one word. Bus decoding and interrupt logic sit outside the block and use the status byte directly.

Top module: `uart_rx_line`

## Requirements
- R1: The line passes through a synchroniser of at least two flops. A bit lasts 16 × D clock cycles, where D is the `divisor` input and a value of 0 acts as 1.
- R2: A falling edge starts a candidate frame. The line is sampled again at the 8th oversampling tick. If it is high by then, the candidate is dropped and no character or flag results.
- R3: Data bits are received LSB first. `word_len` selects 5, 6, 7 or 8 bits (codes 0, 1, 2, 3), and the unused upper bits of `rx_byte` read as zero.
- R4: `parity_cfg[0]` enables a parity bit after the data. `parity_cfg[1]` selects even parity and `parity_cfg[2]` selects stick parity, in which the expected bit is the inverse of `parity_cfg[1]`. A mismatch sets status bit 2.
- R5: Only the first stop bit is checked. If it is sampled low, status bit 3 (framing) is set, and no new start bit is searched for until the line has returned high.
- R6: If every data sample, the parity sample (when enabled) and the stop sample are all low, status bit 4 (break) is set.
- R7: When a frame completes and the buffer is free, the character is loaded into `rx_byte` and status bit 0 (data ready) is set. A one-cycle pulse on `rbr_rd` clears bit 0.
- R8: If a frame completes while bit 0 is set and `rbr_rd` is not asserted in that cycle, status bit 1 (overrun) is set and `rx_byte` keeps the old character. The parity, framing and break results of the discarded frame are still recorded.
- R9: A one-cycle pulse on `lsr_rd` clears status bits 1 to 4. A flag raised by a frame that completes in the same cycle stays set.
- R10: Status bit 5 equals `thre_in`, bit 6 equals `temt_in` and bit 7 reads 0. After reset, `rx_byte` is 0 and bits 0 to 4 are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd | input | 1 | Serial input, idle high |
| divisor | input | DIV_W (16) | Clock cycles per oversampling tick |
| word_len | input | 2 | Data bits: 0=5, 1=6, 2=7, 3=8 |
| parity_cfg | input | 3 | {stick, even, enable} |
| rbr_rd | input | 1 | Receive-buffer read strobe |
| lsr_rd | input | 1 | Status read strobe |
| thre_in | input | 1 | Transmit holding empty, from the transmitter |
| temt_in | input | 1 | Transmitter empty, from the transmitter |
| rx_byte | output | 8 | Receive buffer |
| line_status | output | 8 | {0, temt, thre, break, framing, parity, overrun, ready} |

## Verification
Random frames are sent with random data, word lengths, parity modes and divisors of 1 to 3. This separates errors in bit order and masking from errors in parity polarity and in bit timing. Some frames carry a deliberately wrong parity bit or a low stop bit. These show whether each error flag is raised alone, and whether the receiver waits for the line to go high again before looking for a start. Reads of the buffer and of the status byte are skipped at random, so that overrun and sticky-flag behaviour appear in many combinations. Directed cases add a short low glitch that must be rejected, a full break, and back-to-back frames with no read in between.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

   typedef enum logic [2:0] {
      RX_IDLE,
      RX_START,
      RX_DATA,
      RX_PAR,
      RX_STOP,
      RX_MARK
   } rx_state_e;

   typedef struct packed {
      logic [7:0] data;
      logic       perr;
      logic       ferr;
      logic       brk;
   } rx_result_t;

   // Expected parity bit for the given data and mode.
   function automatic logic expected_parity(input logic [7:0] d,
                                            input logic even,
                                            input logic stick);
      if (stick)     return ~even;
      else if (even) return ^d;
      else           return ~(^d);
   endfunction

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("uart_rx_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '1;
      else        chain_q <= {chain_q[STAGES-2:0], din};
   end

   assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/uart_rx_baud.sv
module uart_rx_baud #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] divisor,
   output logic             tick
);
   logic [DIV_W-1:0] cnt_q;
   logic [DIV_W-1:0] limit;

   assign limit = (divisor == '0) ? '0 : divisor - DIV_W'(1);
   assign tick  = (cnt_q >= limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt_q <= '0;
      else if (tick) cnt_q <= '0;
      else           cnt_q <= cnt_q + DIV_W'(1);
   end
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
   import uart_rx_pkg::*;
#(
   parameter int OVS = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       rx_s,
   input  logic [1:0] word_len,
   input  logic [2:0] parity_cfg,
   output rx_result_t res,
   output logic       res_vld
);
   localparam int CW = $clog2(OVS);
   localparam logic [CW-1:0] HALF_M1 = CW'(OVS / 2 - 1);
   localparam logic [CW-1:0] FULL_M1 = CW'(OVS - 1);

   rx_state_e  state_q;
   logic [CW-1:0] cnt_q;
   logic [2:0] idx_q;
   logic [7:0] data_q;
   logic       par_q;
   rx_result_t res_q;
   logic       res_vld_q;
   logic [2:0] last_idx;
   logic       pen;
   logic       mid_bit;

   assign last_idx = 3'd4 + {1'b0, word_len};
   assign pen      = parity_cfg[0];
   assign mid_bit  = tick && (cnt_q == FULL_M1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= RX_IDLE;
         cnt_q     <= '0;
         idx_q     <= '0;
         data_q    <= '0;
         par_q     <= 1'b0;
         res_q     <= '0;
         res_vld_q <= 1'b0;
      end else begin
         res_vld_q <= 1'b0;
         if (tick && !mid_bit) cnt_q <= cnt_q + CW'(1);
         case (state_q)
            RX_IDLE: begin
               if (tick && !rx_s) begin
                  state_q <= RX_START;
                  cnt_q   <= '0;
               end
            end
            RX_START: begin
               if (tick && cnt_q == HALF_M1) begin
                  cnt_q <= '0;
                  if (rx_s) begin
                     state_q <= RX_IDLE;
                  end else begin
                     state_q <= RX_DATA;
                     idx_q   <= '0;
                     data_q  <= '0;
                     par_q   <= 1'b0;
                  end
               end
            end
            RX_DATA: begin
               if (mid_bit) begin
                  cnt_q         <= '0;
                  data_q[idx_q] <= rx_s;
                  if (idx_q == last_idx) state_q <= pen ? RX_PAR : RX_STOP;
                  else                   idx_q   <= idx_q + 3'd1;
               end
            end
            RX_PAR: begin
               if (mid_bit) begin
                  cnt_q   <= '0;
                  par_q   <= rx_s;
                  state_q <= RX_STOP;
               end
            end
            RX_STOP: begin
               if (mid_bit) begin
                  cnt_q      <= '0;
                  res_vld_q  <= 1'b1;
                  res_q.data <= data_q;
                  res_q.ferr <= !rx_s;
                  res_q.perr <= pen &&
                     (par_q != expected_parity(data_q, parity_cfg[1], parity_cfg[2]));
                  res_q.brk  <= !rx_s && (data_q == '0) && (!pen || !par_q);
                  state_q    <= rx_s ? RX_IDLE : RX_MARK;
               end
            end
            RX_MARK: begin
               if (rx_s) state_q <= RX_IDLE;
            end
            default: state_q <= RX_IDLE;
         endcase
      end
   end

   assign res     = res_q;
   assign res_vld = res_vld_q;

   // R2
   start_confirm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == RX_DATA && $past(state_q) == RX_START) |-> !$past(rx_s));
   // R6
   break_implies_framing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_vld_q && res_q.brk) |-> res_q.ferr);
   // R7
   single_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_vld_q |=> !res_vld_q);
   // R5
   mark_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(state_q) == RX_MARK && state_q == RX_IDLE) |-> $past(rx_s));
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
   import uart_rx_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  rx_result_t res,
   input  logic       res_vld,
   input  logic       rbr_rd,
   input  logic       lsr_rd,
   input  logic       thre_in,
   input  logic       temt_in,
   output logic [7:0] rbr,
   output logic [7:0] lsr
);
   logic [7:0] rbr_q;
   logic dr_q, oe_q, pe_q, fe_q, bi_q;
   logic load;

   assign load = res_vld && (!dr_q || rbr_rd);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rbr_q <= '0;
         dr_q  <= 1'b0;
         oe_q  <= 1'b0;
         pe_q  <= 1'b0;
         fe_q  <= 1'b0;
         bi_q  <= 1'b0;
      end else begin
         if (load) begin
            rbr_q <= res.data;
            dr_q  <= 1'b1;
         end else if (rbr_rd) begin
            dr_q  <= 1'b0;
         end
         if (res_vld && dr_q && !rbr_rd) oe_q <= 1'b1;
         else if (lsr_rd)                oe_q <= 1'b0;
         if (res_vld && res.perr)        pe_q <= 1'b1;
         else if (lsr_rd)                pe_q <= 1'b0;
         if (res_vld && res.ferr)        fe_q <= 1'b1;
         else if (lsr_rd)                fe_q <= 1'b0;
         if (res_vld && res.brk)         bi_q <= 1'b1;
         else if (lsr_rd)                bi_q <= 1'b0;
      end
   end

   assign rbr = rbr_q;
   assign lsr = {1'b0, temt_in, thre_in, bi_q, fe_q, pe_q, oe_q, dr_q};

   // R7
   ready_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dr_q) |-> $past(rbr_rd));
   // R8
   overrun_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(oe_q) |-> $past(dr_q) && $past(res_vld));
   // R8
   buffer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rbr_q) |-> dr_q);
   // R9
   framing_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(fe_q) |-> $past(lsr_rd));
endmodule

// File: rtl/uart_rx_line.sv
module uart_rx_line
   import uart_rx_pkg::*;
#(
   parameter int DIV_W       = 16,
   parameter int OVS         = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rxd,
   input  logic [DIV_W-1:0] divisor,
   input  logic [1:0]       word_len,
   input  logic [2:0]       parity_cfg,
   input  logic             rbr_rd,
   input  logic             lsr_rd,
   input  logic             thre_in,
   input  logic             temt_in,
   output logic [7:0]       rx_byte,
   output logic [7:0]       line_status
);
   generate
      if (OVS < 4 || (OVS % 2) != 0) begin : g_bad_ovs
         $error("uart_rx_line: OVS must be even and at least 4");
      end
      if (DIV_W < 1) begin : g_bad_div
         $error("uart_rx_line: DIV_W must be positive");
      end
   endgenerate

   logic       rx_s;
   logic       tick;
   rx_result_t res;
   logic       res_vld;

   uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(rxd), .dout(rx_s));

   uart_rx_baud #(.DIV_W(DIV_W)) u_baud (
      .clk(clk), .rst_n(rst_n), .divisor(divisor), .tick(tick));

   uart_rx_frame #(.OVS(OVS)) u_frame (
      .clk(clk), .rst_n(rst_n), .tick(tick), .rx_s(rx_s),
      .word_len(word_len), .parity_cfg(parity_cfg),
      .res(res), .res_vld(res_vld));

   uart_rx_status u_status (
      .clk(clk), .rst_n(rst_n), .res(res), .res_vld(res_vld),
      .rbr_rd(rbr_rd), .lsr_rd(lsr_rd),
      .thre_in(thre_in), .temt_in(temt_in),
      .rbr(rx_byte), .lsr(line_status));

   // R10
   status_top_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      line_status[7] == 1'b0 && line_status[6] == temt_in);
endmodule

// File: tb/uart_rx_line_test.sv
module uart_rx_line_test;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        rxd;
   logic [15:0] divisor;
   logic [1:0]  word_len;
   logic [2:0]  parity_cfg;
   logic        rbr_rd, lsr_rd, thre_in, temt_in;
   logic [7:0]  rx_byte, line_status;

   int n_chk = 0;
   int n_fail = 0;
   logic done = 1'b0;

   // bench model
   logic [7:0] m_rbr;
   logic m_dr, m_oe, m_pe, m_fe, m_bi;

   always #5 clk = ~clk;

   uart_rx_line uut (
      .clk(clk), .rst_n(rst_n), .rxd(rxd), .divisor(divisor),
      .word_len(word_len), .parity_cfg(parity_cfg),
      .rbr_rd(rbr_rd), .lsr_rd(lsr_rd), .thre_in(thre_in), .temt_in(temt_in),
      .rx_byte(rx_byte), .line_status(line_status));

   function automatic logic [7:0] ref_status();
      return {1'b0, temt_in, thre_in, m_bi, m_fe, m_pe, m_oe, m_dr};
   endfunction

   function automatic logic ref_parity(input logic [7:0] d);
      if (parity_cfg[2])      return ~parity_cfg[1];
      else if (parity_cfg[1]) return ^d;
      else                    return ~(^d);
   endfunction

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic drive(input logic v, input int n);
      rxd = v;
      repeat (n) @(negedge clk);
   endtask

   task automatic send_frame(input logic [7:0] d, input logic bad_par,
                             input logic bad_stop, input logic brk);
      int nb;
      int bt;
      logic [7:0] dm;
      logic pb, sb;
      nb = 5 + int'(word_len);
      bt = 16 * ((divisor == 16'd0) ? 1 : int'(divisor));
      dm = brk ? 8'h00 : (d & 8'(( 1 << nb) - 1));
      pb = brk ? 1'b0 : (ref_parity(dm) ^ bad_par);
      sb = !(brk || bad_stop);
      drive(1'b0, bt);
      for (int i = 0; i < nb; i++) drive(dm[i], bt);
      if (parity_cfg[0]) drive(pb, bt);
      drive(sb, bt);
      if (!sb) drive(1'b1, 2 * bt);
      else     drive(1'b1, 4);
      repeat (6) @(negedge clk);
      // model
      if (parity_cfg[0] && (pb != ref_parity(dm))) m_pe = 1'b1;
      if (!sb) m_fe = 1'b1;
      if (!sb && dm == 8'h00 && (!parity_cfg[0] || !pb)) m_bi = 1'b1;
      if (m_dr) m_oe = 1'b1;
      else begin
         m_rbr = dm;
         m_dr  = 1'b1;
      end
   endtask

   task automatic read_rbr();
      rbr_rd = 1'b1;
      @(negedge clk);
      rbr_rd = 1'b0;
      m_dr = 1'b0;
   endtask

   task automatic read_lsr();
      lsr_rd = 1'b1;
      @(negedge clk);
      lsr_rd = 1'b0;
      {m_oe, m_pe, m_fe, m_bi} = 4'b0000;
   endtask

   task automatic check_all(input string req);
      chk(req, rx_byte, m_rbr);
      chk(req, line_status, ref_status());
   endtask

   initial begin
      rst_n = 1'b0; rxd = 1'b1; divisor = 16'd2; word_len = 2'd3;
      parity_cfg = 3'b000; rbr_rd = 1'b0; lsr_rd = 1'b0;
      thre_in = 1'b1; temt_in = 1'b1;
      m_rbr = 8'h00; {m_dr, m_oe, m_pe, m_fe, m_bi} = 5'b0;
      void'($urandom(32'd4711));
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10 reset", rx_byte, 8'h00);
      chk("R10 reset", line_status, 8'h60);

      // R1 R3: 8 data bits, no parity, divisor 1
      divisor = 16'd1;
      send_frame(8'hA5, 1'b0, 1'b0, 1'b0);
      check_all("R1/R3 8N1");
      read_rbr();
      check_all("R7 clear");

      // R2: short glitch must be rejected
      divisor = 16'd2;
      drive(1'b0, 4 * 2);
      drive(1'b1, 3 * 32);
      check_all("R2 glitch");

      // R3: 5-bit word masks upper bits
      word_len = 2'd0;
      send_frame(8'hFF, 1'b0, 1'b0, 1'b0);
      check_all("R3 five bits");
      read_rbr();

      // R6: break with even parity
      word_len = 2'd3; parity_cfg = 3'b011;
      send_frame(8'h00, 1'b0, 1'b0, 1'b1);
      check_all("R6 break");
      read_rbr(); read_lsr();
      check_all("R9 clear");

      // R8: two frames without reading
      parity_cfg = 3'b001;
      send_frame(8'h3C, 1'b0, 1'b0, 1'b0);
      send_frame(8'hC3, 1'b1, 1'b0, 1'b0);
      check_all("R8 overrun");
      read_lsr();
      check_all("R9 clear after overrun");
      read_rbr();

      // random vectors
      for (int v = 0; v < 60; v++) begin
         logic [31:0] r;
         r = $urandom;
         divisor    = 16'(1 + (r[1:0] % 3));
         word_len   = r[3:2];
         parity_cfg = r[6:4];
         thre_in    = r[7];
         temt_in    = r[8];
         send_frame(r[23:16], (r[11:9] == 3'd0), (r[14:12] == 3'd0), 1'b0);
         check_all("R3/R4/R5/R6/R7/R8/R10 random");
         if (r[25:24] != 2'd0) read_rbr();
         if (r[27:26] != 2'd0) read_lsr();
         check_all("R7/R9 after reads");
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end
endmodule